// File: doc/BRIEF.md
# Hamming ECC Syndrome Checker and Single-Bit Corrector

This block takes the error-correction code held in flash spare bytes for a 256-byte data chunk and the code recomputed from the data as it was read back. It compares the two and sorts the result into one of four outcomes. The data may be clean. The stored code itself may be damaged. A single data bit may be wrong and fixable. Or the damage may be beyond repair. A code word holds two 11-bit parity fields. One field is a set of line parities. The other is built so that, for a single flipped data bit, the two halves of the difference are bitwise complements.

When a single data bit is wrong, the block reports the byte index and the bit index of the failing bit. If correction is enabled, it also repairs the bit in an external chunk buffer. To do so it reads the byte through a synchronous read port, XORs it with a one-hot mask, and writes it back. A 512-byte page is handled as two 256-byte chunks, each with its own pair of codes. The chunks are checked one after the other, and the second chunk's byte address is offset by 256. A final pulse marks the end of the page and carries the OR of the error flags of all chunks.

Top module: `ecc_hsyn_fix`

## Requirements
- R1: Within each 24-bit code, bits 10:0 hold the first parity field and bits 21:11 hold the second. Bits 23:22 take no part in classification.
- R2: Status 00 (clean) is reported when the syndrome (calc XOR stored, 22 bits) is zero, or when either code is all zeros. No buffer access follows.
- R3: Status 01 (code damaged) is reported when exactly one syndrome bit is set. This raises the error flag and causes no buffer access.
- R4: Status 10 (correctable) is reported when the syndrome has exactly 11 ones and (calc_lo XOR calc_hi) XOR (stored_lo XOR stored_hi) equals 0x7FF. The bit index is syndrome bits 2:0 and the byte index is syndrome bits 10:3. This status does not raise the error flag.
- R5: Every other syndrome gives status 11 (uncorrectable), which raises the error flag and causes no buffer access.
- R6: For status 10 with fix_en sampled high at start, the block reads the failing byte and then writes it back with only the reported bit inverted. With fix_en low, the buffer is not touched.
- R7: A start sampled on clock edge k produces a one-cycle res_valid for the first chunk after edge k+2.
- R8: With page512 high, the block reports the second chunk from the _b codes with res_chunk=1 and res_byte_addr = 256 + byte index. The second report comes two cycles after the first when no fix is done. With page512 low, only one report is made.
- R9: done pulses for one cycle once the last chunk has finished, after any write-back. done_err equals the OR of the chunk error flags.
- R10: A start asserted while a page is in progress is ignored. Codes presented with that start have no effect.
- R11: While rst is high and on the cycle after it, res_valid, done, fix_rd_en and fix_wr_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin checking one page (sampled when idle) |
| page512 | input | 1 | 1: two chunks, 0: one chunk |
| fix_en | input | 1 | Enable write-back of correctable errors |
| calc_code_a | input | 24 | Recomputed code, chunk 0 |
| stored_code_a | input | 24 | Stored code, chunk 0 |
| calc_code_b | input | 24 | Recomputed code, chunk 1 |
| stored_code_b | input | 24 | Stored code, chunk 1 |
| res_valid | output | 1 | One-cycle per-chunk report strobe |
| res_status | output | 2 | 00 clean, 01 code damaged, 10 corrected, 11 uncorrectable |
| res_chunk | output | 1 | Chunk number of the report |
| res_byte_addr | output | 9 | Failing byte address within the page (status 10) |
| res_bit | output | 3 | Failing bit within the byte (status 10) |
| done | output | 1 | One-cycle end-of-page strobe |
| done_err | output | 1 | OR of chunk error flags, valid with done |
| fix_rd_en | output | 1 | Buffer read strobe |
| fix_wr_en | output | 1 | Buffer write strobe |
| fix_addr | output | 9 | Buffer byte address |
| fix_rd_data | input | 8 | Buffer read data, one cycle after fix_rd_en |
| fix_wr_data | output | 8 | Buffer write data |

## Verification
The bench probes the edges of the classifier. It sends an all-zero code on either side with a nonzero syndrome, which a design that only tests the syndrome would call damaged or uncorrectable. It sends an 11-ones syndrome whose halves are not complements, which a popcount-only design would wrongly correct. It flips only bits 23:22, which a design that used the full 24 bits would flag, and it uses a syndrome whose low field is zero to hit byte 0, bit 0. The two-chunk page pairs a damaged code in chunk 0 with a repair in chunk 1. A design that drops the 256 offset would corrupt the wrong byte, and one that keeps only the last chunk's flag would clear done_err. A start repeated while busy, carrying different codes, catches a design that re-arms mid-page.

// File: rtl/ecc_hsyn_pkg.sv
package ecc_hsyn_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_ECC_ONLY = 2'b01,
    ST_CORR     = 2'b10,
    ST_UNCORR   = 2'b11
  } ecc_stat_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_CLASS,
    FS_RD,
    FS_MOD,
    FS_NEXT
  } fsm_e;
endpackage

// File: rtl/ecc_hsyn_popcnt.sv
module ecc_hsyn_popcnt #(
  parameter int W  = 22,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] ones
);
  logic [CW-1:0] acc [W+1];
  assign acc[0] = '0;
  for (genvar i = 0; i < W; i++) begin : g_sum
    assign acc[i+1] = acc[i] + CW'(vec[i]);
  end
  assign ones = acc[W];
endmodule

// File: rtl/ecc_hsyn_classify.sv
module ecc_hsyn_classify
  import ecc_hsyn_pkg::*;
#(
  parameter int PAR_W = 11,
  parameter int BIT_W = 3,
  localparam int FIELD_W = 2 * PAR_W,
  localparam int IDX_W = PAR_W - BIT_W
) (
  input  logic [FIELD_W-1:0] calc,
  input  logic [FIELD_W-1:0] stored,
  output ecc_stat_e          status,
  output logic [IDX_W-1:0]   byte_idx,
  output logic [BIT_W-1:0]   bit_idx
);
  localparam int CW = $clog2(FIELD_W + 1);

  logic [FIELD_W-1:0] syn;
  logic [PAR_W-1:0]   fold;
  logic [CW-1:0]      ones;

  assign syn  = calc ^ stored;
  assign fold = (calc[PAR_W-1:0] ^ calc[FIELD_W-1:PAR_W]) ^
                (stored[PAR_W-1:0] ^ stored[FIELD_W-1:PAR_W]);

  ecc_hsyn_popcnt #(.W(FIELD_W), .CW(CW)) pop_i (.vec(syn), .ones(ones));

  always_comb begin
    if (syn == '0 || calc == '0 || stored == '0)
      status = ST_CLEAN;
    else if (ones == CW'(1))
      status = ST_ECC_ONLY;
    else if (ones == CW'(PAR_W) && fold == '1)
      status = ST_CORR;
    else
      status = ST_UNCORR;
  end

  assign bit_idx  = syn[BIT_W-1:0];
  assign byte_idx = syn[PAR_W-1:BIT_W];
endmodule

// File: rtl/ecc_hsyn_bitmask.sv
module ecc_hsyn_bitmask #(
  parameter int BYTE_W = 8,
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic [BIT_W-1:0]  bit_idx,
  output logic [BYTE_W-1:0] mask
);
  for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
    assign mask[i] = (bit_idx == BIT_W'(i));
  end
endmodule

// File: rtl/ecc_hsyn_fix.sv
module ecc_hsyn_fix
  import ecc_hsyn_pkg::*;
#(
  parameter int PAR_W  = 11,
  parameter int CODE_W = 24,
  parameter int BYTE_W = 8,
  localparam int BIT_W   = $clog2(BYTE_W),
  localparam int IDX_W   = PAR_W - BIT_W,
  localparam int ADDR_W  = IDX_W + 1,
  localparam int FIELD_W = 2 * PAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              page512,
  input  logic              fix_en,
  input  logic [CODE_W-1:0] calc_code_a,
  input  logic [CODE_W-1:0] stored_code_a,
  input  logic [CODE_W-1:0] calc_code_b,
  input  logic [CODE_W-1:0] stored_code_b,
  output logic              res_valid,
  output logic [1:0]        res_status,
  output logic              res_chunk,
  output logic [ADDR_W-1:0] res_byte_addr,
  output logic [BIT_W-1:0]  res_bit,
  output logic              done,
  output logic              done_err,
  output logic              fix_rd_en,
  output logic              fix_wr_en,
  output logic [ADDR_W-1:0] fix_addr,
  input  logic [BYTE_W-1:0] fix_rd_data,
  output logic [BYTE_W-1:0] fix_wr_data
);
  localparam int NCHUNK = 2;

  fsm_e               state_q;
  logic               busy;
  logic [FIELD_W-1:0] cap_calc   [NCHUNK];
  logic [FIELD_W-1:0] cap_stored [NCHUNK];
  logic               page512_q, fix_en_q, chunk_q, err_acc;
  logic [BYTE_W-1:0]  mask_q;

  ecc_stat_e          cls_status;
  logic [IDX_W-1:0]   cls_byte;
  logic [BIT_W-1:0]   cls_bit;
  logic [BYTE_W-1:0]  cls_mask;
  logic               unused_hi;

  assign busy = (state_q != FS_IDLE);
  assign unused_hi = ^{calc_code_a[CODE_W-1:FIELD_W], stored_code_a[CODE_W-1:FIELD_W],
                       calc_code_b[CODE_W-1:FIELD_W], stored_code_b[CODE_W-1:FIELD_W]};

  ecc_hsyn_classify #(.PAR_W(PAR_W), .BIT_W(BIT_W)) cls_i (
    .calc     (cap_calc[chunk_q]),
    .stored   (cap_stored[chunk_q]),
    .status   (cls_status),
    .byte_idx (cls_byte),
    .bit_idx  (cls_bit)
  );

  ecc_hsyn_bitmask #(.BYTE_W(BYTE_W)) mask_i (.bit_idx(cls_bit), .mask(cls_mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= FS_IDLE;
      page512_q     <= 1'b0;
      fix_en_q      <= 1'b0;
      chunk_q       <= 1'b0;
      err_acc       <= 1'b0;
      mask_q        <= '0;
      res_valid     <= 1'b0;
      res_status    <= 2'b00;
      res_chunk     <= 1'b0;
      res_byte_addr <= '0;
      res_bit       <= '0;
      done          <= 1'b0;
      done_err      <= 1'b0;
      fix_rd_en     <= 1'b0;
      fix_wr_en     <= 1'b0;
      fix_addr      <= '0;
      fix_wr_data   <= '0;
      for (int i = 0; i < NCHUNK; i++) begin
        cap_calc[i]   <= '0;
        cap_stored[i] <= '0;
      end
    end else begin
      res_valid <= 1'b0;
      done      <= 1'b0;
      fix_rd_en <= 1'b0;
      fix_wr_en <= 1'b0;
      case (state_q)
        FS_IDLE: begin
          if (start) begin
            cap_calc[0]   <= calc_code_a[FIELD_W-1:0];
            cap_stored[0] <= stored_code_a[FIELD_W-1:0];
            cap_calc[1]   <= calc_code_b[FIELD_W-1:0];
            cap_stored[1] <= stored_code_b[FIELD_W-1:0];
            page512_q     <= page512;
            fix_en_q      <= fix_en;
            chunk_q       <= 1'b0;
            err_acc       <= 1'b0;
            state_q       <= FS_CLASS;
          end
        end
        FS_CLASS: begin
          res_valid  <= 1'b1;
          res_status <= cls_status;
          res_chunk  <= chunk_q;
          if (cls_status == ST_CORR) begin
            res_byte_addr <= {chunk_q, cls_byte};
            res_bit       <= cls_bit;
          end else begin
            res_byte_addr <= '0;
            res_bit       <= '0;
          end
          if (cls_status == ST_ECC_ONLY || cls_status == ST_UNCORR)
            err_acc <= 1'b1;
          if (cls_status == ST_CORR && fix_en_q) begin
            fix_rd_en <= 1'b1;
            fix_addr  <= {chunk_q, cls_byte};
            mask_q    <= cls_mask;
            state_q   <= FS_RD;
          end else begin
            state_q <= FS_NEXT;
          end
        end
        FS_RD: state_q <= FS_MOD;
        FS_MOD: begin
          fix_wr_en   <= 1'b1;
          fix_wr_data <= fix_rd_data ^ mask_q;
          state_q     <= FS_NEXT;
        end
        FS_NEXT: begin
          if (page512_q && !chunk_q) begin
            chunk_q <= 1'b1;
            state_q <= FS_CLASS;
          end else begin
            done     <= 1'b1;
            done_err <= err_acc;
            state_q  <= FS_IDLE;
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecc_hsyn_fix_chk.sv
module ecc_hsyn_fix_chk
  import ecc_hsyn_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              res_valid,
  input logic [1:0]        res_status,
  input logic              res_chunk,
  input logic [ADDR_W-1:0] res_byte_addr,
  input logic              done,
  input logic              fix_rd_en,
  input logic              fix_wr_en,
  input logic [ADDR_W-1:0] fix_addr
);
  a_r2_clean_no_access: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status == ST_CLEAN) |-> !fix_rd_en);

  a_r3_code_damage_no_access: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status == ST_ECC_ONLY) |-> !fix_rd_en);

  a_r5_uncorr_no_access: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status == ST_UNCORR) |-> !fix_rd_en);

  a_r6_read_only_on_corr: assert property (@(posedge clk) disable iff (rst)
    fix_rd_en |-> (res_valid && res_status == ST_CORR && fix_addr == res_byte_addr));

  a_r6_write_after_read: assert property (@(posedge clk) disable iff (rst)
    fix_wr_en |-> ($past(fix_rd_en, 2) && $stable(fix_addr)));

  a_r7_report_latency: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> ##1 res_valid);

  a_r8_second_chunk_offset: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_chunk && res_status == ST_CORR) |-> res_byte_addr[ADDR_W-1]);

  a_r9_done_apart_from_report: assert property (@(posedge clk) disable iff (rst)
    !(done && res_valid));

  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> (!res_valid && !done && !fix_rd_en && !fix_wr_en));
endmodule

bind ecc_hsyn_fix ecc_hsyn_fix_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .busy          (busy),
  .res_valid     (res_valid),
  .res_status    (res_status),
  .res_chunk     (res_chunk),
  .res_byte_addr (res_byte_addr),
  .done          (done),
  .fix_rd_en     (fix_rd_en),
  .fix_wr_en     (fix_wr_en),
  .fix_addr      (fix_addr)
);

// File: tb/ecc_hsyn_fix_tb_top.sv
module ecc_hsyn_fix_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] S0 = 24'h15A3C6;
  localparam int NVEC = 10;
  // vector: {calc[24], stored[24], status[2], byte[8], bit[3]}
  localparam logic [60:0] VECS [NVEC] = '{
    {S0, S0, 2'd0, 8'h00, 3'd0},
    {24'h000000, S0, 2'd0, 8'h00, 3'd0},
    {S0 ^ 24'hC00000, S0, 2'd0, 8'h00, 3'd0},
    {S0 ^ 24'h000400, S0, 2'd1, 8'h00, 3'd0},
    {S0 ^ 24'h200000, S0, 2'd1, 8'h00, 3'd0},
    {S0 ^ {2'b00, 11'h54A, 11'h2B5}, S0, 2'd2, 8'h56, 3'd5},
    {S0 ^ {2'b00, 11'h7FF, 11'h000}, S0, 2'd2, 8'h00, 3'd0},
    {S0 ^ {2'b00, 11'h001, 11'h3FF}, S0, 2'd3, 8'h00, 3'd0},
    {S0 ^ 24'h000003, S0, 2'd3, 8'h00, 3'd0},
    {S0, 24'h000000, 2'd0, 8'h00, 3'd0}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, page512 = 1'b0, fix_en = 1'b0;
  logic [23:0] calc_code_a = '0, stored_code_a = '0, calc_code_b = '0, stored_code_b = '0;
  logic res_valid, res_chunk, done, done_err, fix_rd_en, fix_wr_en;
  logic [1:0] res_status;
  logic [8:0] res_byte_addr, fix_addr;
  logic [2:0] res_bit;
  logic [7:0] fix_rd_data, fix_wr_data;
  logic [7:0] mem [512];

  int nchk = 0, nfail = 0;
  int nrep;
  logic [1:0] r_st [2];
  logic       r_ch [2];
  logic [8:0] r_ad [2];
  logic [2:0] r_bi [2];
  int         r_cyc [2];
  logic       d_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_hsyn_fix dut_i (
    .clk(clk), .rst(rst), .start(start), .page512(page512), .fix_en(fix_en),
    .calc_code_a(calc_code_a), .stored_code_a(stored_code_a),
    .calc_code_b(calc_code_b), .stored_code_b(stored_code_b),
    .res_valid(res_valid), .res_status(res_status), .res_chunk(res_chunk),
    .res_byte_addr(res_byte_addr), .res_bit(res_bit), .done(done), .done_err(done_err),
    .fix_rd_en(fix_rd_en), .fix_wr_en(fix_wr_en), .fix_addr(fix_addr),
    .fix_rd_data(fix_rd_data), .fix_wr_data(fix_wr_data)
  );

  always @(posedge clk) begin
    if (fix_rd_en) fix_rd_data <= mem[fix_addr];
    if (fix_wr_en) mem[fix_addr] <= fix_wr_data;
  end

  function automatic logic [7:0] init_val(input int a);
    return a[7:0] ^ 8'h3C;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [23:0] ca, sa, cb, sb, input logic p512, fe);
    int cyc = 0;
    bit got_done = 0;
    nrep = 0;
    d_err = 1'b0;
    @(negedge clk);
    calc_code_a = ca; stored_code_a = sa; calc_code_b = cb; stored_code_b = sb;
    page512 = p512; fix_en = fe; start = 1'b1;
    while (!got_done && cyc < 40) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (res_valid && nrep < 2) begin
        r_st[nrep] = res_status; r_ch[nrep] = res_chunk; r_ad[nrep] = res_byte_addr;
        r_bi[nrep] = res_bit; r_cyc[nrep] = cyc; nrep++;
      end
      if (done) begin
        got_done = 1;
        d_err = done_err;
      end
    end
    chk("R9 done seen", got_done, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 res_valid", res_valid, 0);
    chk("R11 done", done, 0);
    chk("R11 fix strobes", {fix_rd_en, fix_wr_en}, 0);
    chk("R11 status", res_status, 0);
    rst = 1'b0;
    @(negedge clk);

    // table walk: single chunk, no fix
    for (int i = 0; i < NVEC; i++) begin
      logic [60:0] v = VECS[i];
      logic [1:0] est = v[12:11];
      string tg = (i == 2) ? "R1" : (est == 2'd0) ? "R2" : (est == 2'd1) ? "R3" :
                  (est == 2'd2) ? "R4" : "R5";
      run(v[60:37], v[36:13], 24'h0, 24'h0, 1'b0, 1'b0);
      chk({tg, " status"}, r_st[0], est);
      chk("R7 latency", r_cyc[0], 2);
      chk("R8 single report", nrep, 1);
      chk("R9 done_err", d_err, (est == 2'd1 || est == 2'd3));
      if (est == 2'd2) begin
        chk({tg, " byte"}, r_ad[0], {1'b0, v[10:3]});
        chk({tg, " bit"}, r_bi[0], v[2:0]);
      end
    end
    chk("R6 no fix no write", mem[9'h056], init_val(9'h056));

    // R6 correction with write-back
    run(S0 ^ {2'b00, 11'h54A, 11'h2B5}, S0, 24'h0, 24'h0, 1'b0, 1'b1);
    chk("R6 flipped byte", mem[9'h056], init_val(9'h056) ^ 8'h20);
    chk("R6 neighbour", mem[9'h057], init_val(9'h057));
    chk("R9 corr no err", d_err, 0);

    // R6 fix_en low leaves buffer alone
    run(S0 ^ {2'b00, 11'h54A, 11'h2B5}, S0, 24'h0, 24'h0, 1'b0, 1'b0);
    chk("R6 fix_en low", mem[9'h056], init_val(9'h056) ^ 8'h20);

    // R8 two chunks: chunk0 code damage, chunk1 correctable byte 1 bit 3
    run(S0 ^ 24'h000001, S0, S0 ^ {2'b00, 11'h7F4, 11'h00B}, S0, 1'b1, 1'b1);
    chk("R8 reports", nrep, 2);
    chk("R8 chunk0 status", r_st[0], 1);
    chk("R8 chunk1 status", r_st[1], 2);
    chk("R8 chunk1 id", r_ch[1], 1);
    chk("R8 chunk1 addr", r_ad[1], 9'h101);
    chk("R8 chunk1 bit", r_bi[1], 3);
    chk("R8 chunk1 timing", r_cyc[1], 4);
    chk("R8 fixed byte", mem[9'h101], init_val(9'h101) ^ 8'h08);
    chk("R8 chunk0 twin untouched", mem[9'h001], init_val(9'h001));
    chk("R9 OR of flags", d_err, 1);

    // R10 start while busy is ignored
    begin
      int cnt = 0;
      logic [1:0] st = 2'b00;
      @(negedge clk);
      calc_code_a = S0; stored_code_a = S0; page512 = 1'b0; fix_en = 1'b0; start = 1'b1;
      @(negedge clk);
      calc_code_a = S0 ^ 24'h000010;
      for (int k = 0; k < 8; k++) begin
        if (k == 1) start = 1'b0;
        if (res_valid) begin cnt++; st = res_status; end
        @(negedge clk);
      end
      start = 1'b0;
      chk("R10 one report", cnt, 1);
      chk("R10 codes ignored", st, 0);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule